// File: doc/BRIEF.md
# Competing Counter Swap Controller

This block decides when a segment in slow memory has earned a place in fast memory. Every fast-memory slot has a small group of slow segments that may be mapped into it. The block watches a stream of already translated accesses. Each access carries the slot it maps to, the segment it names, and a flag saying whether it hit the segment currently held in fast memory. For each slot it keeps one shared up/down counter and the identity of one tracked challenger. Challenger accesses push the counter up and fast-resident accesses push it down, so the counter holds only the relative activity of the two, not their absolute counts.

When a challenger access brings the counter to the programmed threshold, the block emits a one-cycle swap request naming the slot and the challenger. A swap may be requested in any cycle. The copy engine that moves the data and rewrites the remapping table sits outside this block. While that engine works, the slot is frozen. The engine returns a done strobe for the slot, and the block then starts tracking that slot again from a cleared state.

Top module: `ccs_swap_tracker`

## Requirements
- R1: After reset every slot has a zero counter, no tracked challenger and no pending swap; `swapReq` is low and the threshold equals `RESET_THRESH` (default 4).
- R2: A slow access (`accFast`=0) whose segment equals the slot's tracked challenger increments that slot's counter, saturating at 2^CNT_W-1.
- R3: A fast access (`accFast`=1) decrements the slot's counter, saturating at zero, and never produces a swap request.
- R4: A slow access from a segment that is not the tracked challenger replaces the challenger only if the counter is zero, and then the counter becomes 1. If the counter is nonzero, the access changes nothing.
- R5: When a challenger access (including the one that installs a new challenger) leaves the counter at or above the threshold, `swapReq` is high for exactly the next cycle. In that cycle `swapSlot` and `swapSeg` carry the access's slot and segment, and the slot becomes pending.
- R6: While a slot is pending, accesses to it change none of its state and raise no further request.
- R7: `doneValid` with `doneSlot` clears that slot's pending flag, counter and challenger. An access to the same slot in the same cycle is ignored.
- R8: A threshold write (`cfgWrEn`) applies to accesses in later cycles. An access in the same cycle as the write is compared against the old threshold. Lowering the threshold below a counter's value makes the next challenger access trigger a request.
- R9: Each slot's counter, challenger and pending state are affected only by accesses or done strobes that name that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access present this cycle |
| accSlot | input | SLOT_W | Fast-memory slot the access maps to |
| accSeg | input | SEG_W | Segment identity of the access |
| accFast | input | 1 | 1: access hit the fast-resident segment; 0: slow segment |
| cfgWrEn | input | 1 | Threshold write strobe |
| cfgThresh | input | CNT_W | New threshold value |
| doneValid | input | 1 | Swap for `doneSlot` completed |
| doneSlot | input | SLOT_W | Slot whose swap completed |
| swapReq | output | 1 | One-cycle swap request |
| swapSlot | output | SLOT_W | Slot to swap, valid with `swapReq` |
| swapSeg | output | SEG_W | Incoming segment, valid with `swapReq` |

## Verification
Completion of a swap and a new access can fall in the same cycle. The bench applies a done strobe for a pending slot together with a slow access to that slot from a fresh segment. It then shows that the access left no challenger behind: a different segment installs itself and triggers after exactly the threshold count. A second collision puts a done strobe on one slot and a triggering access on another in the same cycle, and the bench expects both to take effect. A threshold write placed in the same cycle as a challenger access is judged by which threshold that access is compared against.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_DEC,
    CNT_INC,
    CNT_LOAD
  } cntOp_e;

  typedef struct packed {
    logic   upd;   // apply op to the accessed slot
    cntOp_e op;    // counter / challenger operation
    logic   fire;  // raise swap request, mark slot pending
    logic   clr;   // clear the slot named by doneSlot
  } ctlStrobe_t;

endpackage

// File: rtl/ccs_ctrl.sv
module ccs_ctrl
  import ccs_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              accValid,
  input  logic              accFast,
  input  logic [SLOT_W-1:0] accSlot,
  input  logic              doneValid,
  input  logic [SLOT_W-1:0] doneSlot,
  input  logic              selPend,
  input  logic              selChalValid,
  input  logic              selChalMatch,
  input  logic              selCntZero,
  input  logic              incReach,
  input  logic              loadReach,
  output ctlStrobe_t        stb
);

  logic blocked;

  // A slot that is pending or is being released this cycle ignores accesses.
  assign blocked = selPend | (doneValid && (doneSlot == accSlot));

  always_comb begin
    stb      = '0;
    stb.op   = CNT_HOLD;
    stb.clr  = doneValid;
    if (accValid && !blocked) begin
      if (accFast) begin
        stb.upd = 1'b1;
        stb.op  = CNT_DEC;
      end else if (selChalValid && selChalMatch) begin
        stb.upd  = 1'b1;
        stb.op   = CNT_INC;
        stb.fire = incReach;
      end else if (selCntZero) begin
        stb.upd  = 1'b1;
        stb.op   = CNT_LOAD;
        stb.fire = loadReach;
      end
    end
  end

endmodule

// File: rtl/ccs_datapath.sv
module ccs_datapath
  import ccs_pkg::*;
#(
  parameter int NUM_SLOTS    = 8,
  parameter int SEG_W        = 8,
  parameter int CNT_W        = 4,
  parameter int RESET_THRESH = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SLOT_W-1:0]    accSlot,
  input  logic [SEG_W-1:0]     accSeg,
  input  logic                 cfgWrEn,
  input  logic [CNT_W-1:0]     cfgThresh,
  input  logic [SLOT_W-1:0]    doneSlot,
  input  ctlStrobe_t           stb,
  output logic                 selPend,
  output logic                 selChalValid,
  output logic                 selChalMatch,
  output logic                 selCntZero,
  output logic                 incReach,
  output logic                 loadReach,
  output logic [NUM_SLOTS-1:0] pendVec,
  output logic                 swapReq,
  output logic [SLOT_W-1:0]    swapSlot,
  output logic [SEG_W-1:0]     swapSeg
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]     cntArr  [NUM_SLOTS];
  logic [SEG_W-1:0]     chalArr [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] chalVldVec;
  logic [CNT_W-1:0]     threshQ;
  logic [CNT_W-1:0]     selCnt;
  logic [CNT_W-1:0]     incCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        threshQ <= CNT_W'(RESET_THRESH);
    else if (cfgWrEn) threshQ <= cfgThresh;
  end

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
      logic [CNT_W-1:0] cntQ;
      logic [SEG_W-1:0] chalQ;
      logic             chalVldQ;
      logic             pendQ;
      logic             clrHere;
      logic             updHere;

      assign clrHere = stb.clr && (doneSlot == SLOT_W'(i));
      assign updHere = stb.upd && (accSlot == SLOT_W'(i));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cntQ     <= '0;
          chalQ    <= '0;
          chalVldQ <= 1'b0;
          pendQ    <= 1'b0;
        end else if (clrHere) begin
          cntQ     <= '0;
          chalVldQ <= 1'b0;
          pendQ    <= 1'b0;
        end else if (updHere) begin
          unique case (stb.op)
            CNT_DEC:  if (cntQ != '0) cntQ <= cntQ - CNT_ONE;
            CNT_INC:  if (cntQ != CNT_MAX) cntQ <= cntQ + CNT_ONE;
            CNT_LOAD: begin
              cntQ     <= CNT_ONE;
              chalQ    <= accSeg;
              chalVldQ <= 1'b1;
            end
            default: ;
          endcase
          if (stb.fire) pendQ <= 1'b1;
        end
      end

      assign cntArr[i]     = cntQ;
      assign chalArr[i]    = chalQ;
      assign chalVldVec[i] = chalVldQ;
      assign pendVec[i]    = pendQ;
    end
  endgenerate

  assign selCnt       = cntArr[accSlot];
  assign selPend      = pendVec[accSlot];
  assign selChalValid = chalVldVec[accSlot];
  assign selChalMatch = (chalArr[accSlot] == accSeg);
  assign selCntZero   = (selCnt == '0);
  assign incCnt       = (selCnt == CNT_MAX) ? selCnt : selCnt + CNT_ONE;
  assign incReach     = (incCnt >= threshQ);
  assign loadReach    = (threshQ <= CNT_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swapReq  <= 1'b0;
      swapSlot <= '0;
      swapSeg  <= '0;
    end else begin
      swapReq <= stb.fire;
      if (stb.fire) begin
        swapSlot <= accSlot;
        swapSeg  <= accSeg;
      end
    end
  end

endmodule

// File: rtl/ccs_swap_tracker.sv
module ccs_swap_tracker
  import ccs_pkg::*;
#(
  parameter int NUM_SLOTS    = 8,
  parameter int SEG_W        = 8,
  parameter int CNT_W        = 4,
  parameter int RESET_THRESH = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [SLOT_W-1:0] accSlot,
  input  logic [SEG_W-1:0]  accSeg,
  input  logic              accFast,
  input  logic              cfgWrEn,
  input  logic [CNT_W-1:0]  cfgThresh,
  input  logic              doneValid,
  input  logic [SLOT_W-1:0] doneSlot,
  output logic              swapReq,
  output logic [SLOT_W-1:0] swapSlot,
  output logic [SEG_W-1:0]  swapSeg
);

  ctlStrobe_t           stb;
  logic                 selPend;
  logic                 selChalValid;
  logic                 selChalMatch;
  logic                 selCntZero;
  logic                 incReach;
  logic                 loadReach;
  logic [NUM_SLOTS-1:0] pendVec;

  ccs_ctrl #(.NUM_SLOTS(NUM_SLOTS)) uCtrl (
    .accValid    (accValid),
    .accFast     (accFast),
    .accSlot     (accSlot),
    .doneValid   (doneValid),
    .doneSlot    (doneSlot),
    .selPend     (selPend),
    .selChalValid(selChalValid),
    .selChalMatch(selChalMatch),
    .selCntZero  (selCntZero),
    .incReach    (incReach),
    .loadReach   (loadReach),
    .stb         (stb)
  );

  ccs_datapath #(
    .NUM_SLOTS   (NUM_SLOTS),
    .SEG_W       (SEG_W),
    .CNT_W       (CNT_W),
    .RESET_THRESH(RESET_THRESH)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .accSlot     (accSlot),
    .accSeg      (accSeg),
    .cfgWrEn     (cfgWrEn),
    .cfgThresh   (cfgThresh),
    .doneSlot    (doneSlot),
    .stb         (stb),
    .selPend     (selPend),
    .selChalValid(selChalValid),
    .selChalMatch(selChalMatch),
    .selCntZero  (selCntZero),
    .incReach    (incReach),
    .loadReach   (loadReach),
    .pendVec     (pendVec),
    .swapReq     (swapReq),
    .swapSlot    (swapSlot),
    .swapSeg     (swapSeg)
  );

endmodule

// File: rtl/ccs_swap_tracker_chk.sv
module ccs_swap_tracker_chk #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 accValid,
  input logic                 accFast,
  input logic [SLOT_W-1:0]    accSlot,
  input logic                 doneValid,
  input logic [SLOT_W-1:0]    doneSlot,
  input logic                 swapReq,
  input logic [SLOT_W-1:0]    swapSlot,
  input logic [NUM_SLOTS-1:0] pendVec
);

  AST_REQ_FROM_SLOW: assert property (@(posedge clk) disable iff (!rstN)
    swapReq |-> $past(accValid && !accFast)); // R5

  AST_REQ_MARKS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    swapReq |-> pendVec[swapSlot]); // R5

  AST_FAST_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accFast) |=> !swapReq); // R3

  AST_PENDING_NO_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && pendVec[accSlot]) |=> !swapReq); // R6

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !pendVec[$past(doneSlot)]); // R7

endmodule

bind ccs_swap_tracker ccs_swap_tracker_chk #(.NUM_SLOTS(NUM_SLOTS)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .accValid (accValid),
  .accFast  (accFast),
  .accSlot  (accSlot),
  .doneValid(doneValid),
  .doneSlot (doneSlot),
  .swapReq  (swapReq),
  .swapSlot (swapSlot),
  .pendVec  (pendVec)
);

// File: tb/ccs_swap_tracker_test.sv
`timescale 1ns/1ps
module ccs_swap_tracker_test;

  localparam int NUM_SLOTS = 8;
  localparam int SEG_W     = 8;
  localparam int CNT_W     = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              accValid = 1'b0;
  logic [SLOT_W-1:0] accSlot = '0;
  logic [SEG_W-1:0]  accSeg = '0;
  logic              accFast = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [CNT_W-1:0]  cfgThresh = '0;
  logic              doneValid = 1'b0;
  logic [SLOT_W-1:0] doneSlot = '0;
  logic              swapReq;
  logic [SLOT_W-1:0] swapSlot;
  logic [SEG_W-1:0]  swapSeg;

  int nTests = 0;
  int nFail  = 0;
  logic gotReq;
  int   gotSlot;
  int   gotSeg;

  always #10 clk = ~clk;

  ccs_swap_tracker #(.NUM_SLOTS(NUM_SLOTS), .SEG_W(SEG_W), .CNT_W(CNT_W),
                     .RESET_THRESH(4)) uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSlot(accSlot),
    .accSeg(accSeg), .accFast(accFast), .cfgWrEn(cfgWrEn),
    .cfgThresh(cfgThresh), .doneValid(doneValid), .doneSlot(doneSlot),
    .swapReq(swapReq), .swapSlot(swapSlot), .swapSeg(swapSeg));

  // One cycle: inputs set after a falling edge, outputs read at the next one.
  task automatic cyc(input logic av, input int sl, input int sg, input logic fs,
                     input logic dv, input int ds, input logic cv, input int ct);
    accValid  = av;  accSlot = SLOT_W'(sl); accSeg = SEG_W'(sg); accFast = fs;
    doneValid = dv;  doneSlot = SLOT_W'(ds);
    cfgWrEn   = cv;  cfgThresh = CNT_W'(ct);
    @(negedge clk);
    gotReq  = swapReq;
    gotSlot = int'(swapSlot);
    gotSeg  = int'(swapSeg);
    accValid = 1'b0; doneValid = 1'b0; cfgWrEn = 1'b0;
  endtask

  task automatic check(input string req, input logic expReq, input int eSlot, input int eSeg);
    nTests++;
    if (gotReq !== expReq || (expReq && (gotSlot != eSlot || gotSeg != eSeg))) begin
      nFail++;
      $display("FAIL %s: req=%0b slot=%0d seg=%0d expected req=%0b slot=%0d seg=%0d",
               req, gotReq, gotSlot, gotSeg, expReq, eSlot, eSeg);
    end
  endtask

  task automatic slow(input int sl, input int sg); cyc(1, sl, sg, 0, 0, 0, 0, 0); endtask
  task automatic fast(input int sl);               cyc(1, sl, 0, 1, 0, 0, 0, 0); endtask
  task automatic done(input int sl);               cyc(0, 0, 0, 0, 1, sl, 0, 0); endtask
  task automatic setThr(input int t);              cyc(0, 0, 0, 0, 0, 0, 1, t);  endtask

  // n slow accesses; the last one is expected to fire or not.
  task automatic runSlow(input string req, input int sl, input int sg, input int n, input logic lastFires);
    for (int k = 0; k < n; k++) begin
      slow(sl, sg);
      check(req, (k == n - 1) ? lastFires : 1'b0, sl, sg);
    end
  endtask

  task automatic testReset();
    repeat (2) begin cyc(0, 0, 0, 0, 0, 0, 0, 0); check("R1 idle after reset", 1'b0, 0, 0); end
    runSlow("R1 R4 R2 R5 default threshold 4", 0, 10, 4, 1'b1);
    done(0);
  endtask

  task automatic testPending();
    runSlow("R5 slot1 trigger", 1, 11, 4, 1'b1);
    runSlow("R6 pending challenger ignored", 1, 11, 3, 1'b0);
    slow(1, 99); check("R6 pending other seg ignored", 1'b0, 0, 0);
    fast(1);     check("R6 pending fast ignored", 1'b0, 0, 0);
    done(1);
    runSlow("R7 fresh count after done", 1, 12, 4, 1'b1);
    done(1);
  endtask

  task automatic testDecrement();
    setThr(3);
    slow(2, 20); slow(2, 20); fast(2);
    check("R3 fast access no request", 1'b0, 0, 0);
    runSlow("R3 decrement needs two more", 2, 20, 2, 1'b1);
    done(2);
    fast(3); fast(3); fast(3);
    check("R3 zero saturation", 1'b0, 0, 0);
    runSlow("R3 from zero needs threshold", 3, 30, 3, 1'b1);
    done(3);
  endtask

  task automatic testReplace();
    slow(4, 40); slow(4, 40);
    runSlow("R4 intruder ignored while nonzero", 4, 41, 5, 1'b0);
    slow(4, 40); check("R4 original challenger fires", 1'b1, 4, 40);
    done(4);
    slow(4, 50); fast(4);
    runSlow("R4 replacement at zero", 4, 51, 3, 1'b1);
    done(4);
  endtask

  task automatic testThreshold();
    setThr(6);
    runSlow("R8 below threshold 6", 5, 60, 4, 1'b0);
    cyc(1, 5, 60, 0, 0, 0, 1, 2);
    check("R8 same-cycle write uses old threshold", 1'b0, 0, 0);
    slow(5, 60); check("R8 lowered threshold fires", 1'b1, 5, 60);
    done(5);
  endtask

  task automatic testDoneCollision();
    setThr(2);
    runSlow("R5 slot6 trigger", 6, 70, 2, 1'b1);
    cyc(1, 6, 71, 0, 1, 6, 0, 0);
    check("R7 access with done ignored", 1'b0, 0, 0);
    runSlow("R7 new challenger after collision", 6, 72, 2, 1'b1);
    done(6);
  endtask

  task automatic testIndependent();
    setThr(3);
    slow(0, 1); slow(7, 2); slow(0, 1); slow(7, 2); fast(7);
    check("R9 interleave quiet", 1'b0, 0, 0);
    slow(0, 1); check("R9 slot0 fires alone", 1'b1, 0, 1);
    slow(7, 2); check("R9 slot7 unaffected", 1'b0, 0, 0);
    cyc(1, 7, 2, 0, 1, 0, 0, 0);
    check("R9 done on other slot with trigger", 1'b1, 7, 2);
    runSlow("R9 slot0 released", 0, 3, 3, 1'b1);
    done(0); done(7);
  endtask

  initial begin
    #(20ns * 200000);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPending();
    testDecrement();
    testReplace();
    testThreshold();
    testDoneCollision();
    testIndependent();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule